// File: doc/BRIEF.md
# Bus-Fed 32-Bit ALU with Stepped Shifter

This block is the arithmetic and logic engine of a small processor datapath built around one shared data bus. Operands arrive one at a time from the bus. A load pulse captures the first operand into register A; instead of the bus value, A can take the constant four, which serves program-counter increments. A second load pulse captures the other operand into register B, either unchanged or bitwise inverted. Register B also keeps a note of which of the two happened.

A capture pulse writes one of four results into register C: the sum from a ripple-carry adder, a single-position shift of A, bitwise OR, or bitwise AND. The adder's carry-in is the note kept with B. Loading B inverted and then adding therefore yields A minus the bus value, with no separate subtractor. Multi-position shifts run one bit per clock. A start pulse copies A into C. A counter then shifts C once per cycle for the requested number of steps, holds a busy flag while it works, and pulses a done flag when the count is used up.

Top module: `bus_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, registers A, B and C are cleared, the inverted-B note is cleared, and `shift_busy` and `shift_done` are 0.
- R2: At an edge where `load_a` is 1, register A takes the value 4 if `a_sel_four` is 1, and otherwise takes `bus_in`.
- R3: At an edge where `load_b` is 1, register B takes `~bus_in` if `b_invert` is 1, and otherwise takes `bus_in`. The adder's carry-in is 1 exactly when the last load of B was inverted.
- R4: At an idle edge (neither busy nor starting) where `cap_c` is 1, C takes the result selected by `fn_sel`: 2'b00 gives A+B+carry-in modulo 2^32, 2'b01 gives a single shift step of A, 2'b10 gives A|B, and 2'b11 gives A&B. The new value is visible after that edge.
- R5: Loading B with `b_invert`=1 from value X, then capturing with `fn_sel`=2'b00, gives C = A − X modulo 2^32.
- R6: A shift step moves every bit by one place. `shift_right`=0 shifts toward the MSB and `shift_right`=1 shifts toward the LSB. With `shift_rotate`=0 the vacated bit is 0. With `shift_rotate`=1, bit 31 enters bit 0 on a left step and bit 0 enters bit 31 on a right step.
- R7: A `shift_start` at idle edge t with `shift_count`=n>0 copies A into C at edge t. C is then shifted once at each of edges t+1 to t+n, using the direction and rotate mode sampled at edge t. `shift_busy` is 1 after edges t to t+n−1, and `shift_done` is 1 only after edge t+n.
- R8: A `shift_start` with `shift_count`=0 copies A into C and raises `shift_done` after that same edge. `shift_busy` stays 0.
- R9: While `shift_busy` is 1, `cap_c` and `shift_start` have no effect on C or on the running shift. Loads of A and B still take effect.
- R10: When an operand load and `cap_c` fall on the same edge, C is computed from the operand values held before that edge.
- R11: When `shift_start` and `cap_c` are both 1 at an idle edge, the shift start takes precedence.
- R12: At an idle edge with neither `cap_c` nor `shift_start`, C keeps its value and `shift_done` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_in | input | 32 | Shared data bus value |
| load_a | input | 1 | Capture operand A |
| a_sel_four | input | 1 | Load constant 4 into A instead of the bus |
| load_b | input | 1 | Capture operand B |
| b_invert | input | 1 | Load B bitwise inverted (subtract setup) |
| cap_c | input | 1 | Capture the selected result into C |
| fn_sel | input | 2 | Result select: 00 add, 01 shift step, 10 OR, 11 AND |
| shift_start | input | 1 | Begin a counted multi-step shift |
| shift_count | input | 5 | Number of shift steps for a counted shift |
| shift_right | input | 1 | Shift direction: 0 toward MSB, 1 toward LSB |
| shift_rotate | input | 1 | 1 selects circular shift, 0 zero fill |
| c_out | output | 32 | Register C |
| shift_busy | output | 1 | Counted shift in progress |
| shift_done | output | 1 | One-cycle pulse when a counted shift completes |

## Verification
Register C has several writers, and two of them can be asked for in the same cycle. A counted shift in flight can collide with a capture request or a second start. An idle capture can collide with a shift start, or with an operand load that changes the very registers it reads. The bench provokes these collisions on purpose in directed cases, and also lets the random stream produce them freely, with loads, captures and starts raised independently every cycle. Each outcome is judged against a cycle-level reference model in the bench: the shift owns C while busy, a start beats a capture, and a capture sees operands from before the edge.

// File: rtl/bus_alu_pkg.sv
// Shared definitions for the bus-fed ALU: result-select encoding.
package bus_alu_pkg;
    typedef enum logic [1:0] {
        FN_ADD   = 2'b00,
        FN_SHIFT = 2'b01,
        FN_OR    = 2'b10,
        FN_AND   = 2'b11
    } fn_e;
endpackage

// File: rtl/alu_operand_regs.sv
// Operand registers A and B.
// A loads either the bus or the constant four; B loads the bus either
// unchanged or inverted, and remembers the choice as the adder carry-in.
// Assumes load strobes are synchronous to clk; reset is synchronous active-low.
module alu_operand_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_in,
    input  logic         load_a,
    input  logic         a_sel_four,
    input  logic         load_b,
    input  logic         b_invert,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q,
    output logic         b_inv_q
);
    localparam logic [W-1:0] FOUR = W'(4);

    // Register A: bus value or the constant four.
    always_ff @(posedge clk) begin
        if (!rst_n)
            a_q <= '0;
        else if (load_a)
            a_q <= a_sel_four ? FOUR : bus_in;
    end

    // Register B and its inversion note.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q     <= '0;
            b_inv_q <= 1'b0;
        end else if (load_b) begin
            b_q     <= b_invert ? ~bus_in : bus_in;
            b_inv_q <= b_invert;
        end
    end
endmodule

// File: rtl/alu_ripple_adder.sv
// Ripple-carry adder built from a chain of W full-adder cells.
// Purely combinational; the carry out of the top cell is not needed.
module alu_ripple_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);
    logic [W-1:0] carry;

    assign carry[0] = cin;

    // One full-adder cell per bit; every cell but the last feeds its neighbour.
    for (genvar i = 0; i < W; i++) begin : g_cell
        assign sum[i] = a[i] ^ b[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
        end
    end
endmodule

// File: rtl/alu_step_shifter.sv
// Single-position shifter: left or right, with zero fill or rotation.
// Purely combinational; one call moves every bit exactly one place.
module alu_step_shifter #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    input  logic         to_right,
    input  logic         rotate,
    output logic [W-1:0] dout
);
    logic fill_left;
    logic fill_right;

    // Bit entering at the vacated end: wrapped bit when rotating, else zero.
    always_comb begin
        fill_left  = rotate & din[W-1];
        fill_right = rotate & din[0];
    end

    // Direction select between the two wired neighbour connections.
    always_comb begin
        if (to_right)
            dout = {fill_right, din[W-1:1]};
        else
            dout = {din[W-2:0], fill_left};
    end
endmodule

// File: rtl/alu_shift_ctrl.sv
// Counted-shift controller.
// Accepts a start only when idle, latches count, direction and rotate mode,
// counts one step per cycle, and pulses done on the final step. A zero
// count finishes at once. Reset is synchronous active-low.
module alu_shift_ctrl #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count,
    input  logic          dir_in,
    input  logic          rot_in,
    output logic          busy,
    output logic          done,
    output logic          dir_q,
    output logic          rot_q,
    output logic          accept
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] left_q;

    // A start counts only when no shift is in progress.
    always_comb accept = start & ~busy;

    // Step counter, busy flag and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else if (busy) begin
            left_q <= left_q - ONE;
            busy   <= (left_q != ONE);
            done   <= (left_q == ONE);
        end else if (accept) begin
            left_q <= count;
            busy   <= (count != '0);
            done   <= (count == '0);
        end else begin
            done   <= 1'b0;
        end
    end

    // Direction and rotate mode are frozen for the whole counted shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            rot_q <= 1'b0;
        end else if (accept) begin
            dir_q <= dir_in;
            rot_q <= rot_in;
        end
    end
endmodule

// File: rtl/bus_alu.sv
// Bus-fed ALU top: operand registers, adder, one-step shifter, AND/OR,
// 4-way result select into register C, and a counted-shift controller.
// Priority on C: running shift, then shift start (C <= A), then capture.
// Assumes a single clock; reset is synchronous active-low.
module bus_alu #(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         bus_in,
    input  logic                 load_a,
    input  logic                 a_sel_four,
    input  logic                 load_b,
    input  logic                 b_invert,
    input  logic                 cap_c,
    input  logic [1:0]           fn_sel,
    input  logic                 shift_start,
    input  logic [$clog2(W)-1:0] shift_count,
    input  logic                 shift_right,
    input  logic                 shift_rotate,
    output logic [W-1:0]         c_out,
    output logic                 shift_busy,
    output logic                 shift_done
);
    import bus_alu_pkg::*;

    localparam int CW = $clog2(W);

    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic         b_inv_q;
    logic [W-1:0] sum;
    logic [W-1:0] sh_in;
    logic         sh_dir;
    logic         sh_rot;
    logic [W-1:0] sh_out;
    logic [W-1:0] result;
    logic [W-1:0] c_q;
    logic         dir_q;
    logic         rot_q;
    logic         accept;
    fn_e          fn;

    alu_operand_regs #(.W(W)) u_ops (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_in     (bus_in),
        .load_a     (load_a),
        .a_sel_four (a_sel_four),
        .load_b     (load_b),
        .b_invert   (b_invert),
        .a_q        (a_q),
        .b_q        (b_q),
        .b_inv_q    (b_inv_q)
    );

    alu_ripple_adder #(.W(W)) u_add (
        .a   (a_q),
        .b   (b_q),
        .cin (b_inv_q),
        .sum (sum)
    );

    // Shifter source: C while a counted shift runs, otherwise A.
    always_comb begin
        sh_in  = shift_busy ? c_q   : a_q;
        sh_dir = shift_busy ? dir_q : shift_right;
        sh_rot = shift_busy ? rot_q : shift_rotate;
    end

    alu_step_shifter #(.W(W)) u_shf (
        .din      (sh_in),
        .to_right (sh_dir),
        .rotate   (sh_rot),
        .dout     (sh_out)
    );

    alu_shift_ctrl #(.CW(CW)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (shift_start),
        .count  (shift_count),
        .dir_in (shift_right),
        .rot_in (shift_rotate),
        .busy   (shift_busy),
        .done   (shift_done),
        .dir_q  (dir_q),
        .rot_q  (rot_q),
        .accept (accept)
    );

    // 4-to-1 result select for a capture into C.
    always_comb begin
        fn = fn_e'(fn_sel);
        unique case (fn)
            FN_ADD:   result = sum;
            FN_SHIFT: result = sh_out;
            FN_OR:    result = a_q | b_q;
            FN_AND:   result = a_q & b_q;
            default:  result = sum;
        endcase
    end

    // Register C with shift > start > capture priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            c_q <= '0;
        else if (shift_busy)
            c_q <= sh_out;
        else if (accept)
            c_q <= a_q;
        else if (cap_c)
            c_q <= result;
    end

    assign c_out = c_q;
endmodule

// File: rtl/bus_alu_checker.sv
// Assertion checker for bus_alu, attached by bind below.
module bus_alu_checker #(
    parameter int W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cap_c,
    input logic [1:0]           fn_sel,
    input logic                 shift_start,
    input logic [$clog2(W)-1:0] shift_count,
    input logic [W-1:0]         c_out,
    input logic                 shift_busy,
    input logic                 shift_done,
    input logic [W-1:0]         a_q,
    input logic [W-1:0]         b_q,
    input logic                 b_inv_q
);
    // R1: reset leaves C cleared and the shift flags low.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (c_out == '0 && !shift_busy && !shift_done));

    // R4 / R3: an idle add capture yields A+B plus the inversion note.
    a_r4_add_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_c && fn_sel == 2'b00 && !shift_busy && !shift_start)
        |=> c_out == $past(a_q + b_q + W'(b_inv_q)));

    // R8: zero count finishes at once with C equal to A.
    a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_start && !shift_busy && shift_count == '0)
        |=> (shift_done && !shift_busy && c_out == $past(a_q)));

    // R7: done never overlaps busy.
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_done && shift_busy));

    // R7: a shift ending always raises done.
    a_r7_end_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_busy) |-> shift_done);

    // R9: busy only begins from a start request.
    a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_busy) |-> $past(shift_start));

    // R12: with nothing requested, C holds and no done appears.
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_c && !shift_busy && !shift_start) |=> ($stable(c_out) && !shift_done));
endmodule

bind bus_alu bus_alu_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_c       (cap_c),
    .fn_sel      (fn_sel),
    .shift_start (shift_start),
    .shift_count (shift_count),
    .c_out       (c_out),
    .shift_busy  (shift_busy),
    .shift_done  (shift_done),
    .a_q         (a_q),
    .b_q         (b_q),
    .b_inv_q     (b_inv_q)
);

// File: tb/tb_bus_alu.sv
`timescale 1ns/1ps
module tb_bus_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_in = '0;
    logic        load_a = 0, a_sel_four = 0, load_b = 0, b_invert = 0;
    logic        cap_c = 0, shift_start = 0, shift_right = 0, shift_rotate = 0;
    logic [1:0]  fn_sel = '0;
    logic [4:0]  shift_count = '0;
    logic [31:0] c_out;
    logic        shift_busy, shift_done;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Reference model state.
    logic [31:0] mA = '0, mB = '0, mC = '0;
    logic        mInv = 0, mBusy = 0, mDone = 0, mDir = 0, mRot = 0;
    int          mLeft = 0;

    bus_alu dut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .load_a(load_a),
        .a_sel_four(a_sel_four), .load_b(load_b), .b_invert(b_invert),
        .cap_c(cap_c), .fn_sel(fn_sel), .shift_start(shift_start),
        .shift_count(shift_count), .shift_right(shift_right),
        .shift_rotate(shift_rotate), .c_out(c_out),
        .shift_busy(shift_busy), .shift_done(shift_done)
    );

    always #2.5 clk = ~clk;

    // One shift step as required by R6.
    function automatic logic [31:0] step(logic [31:0] v, logic rt, logic rot);
        if (rt) return {rot ? v[0] : 1'b0, v[31:1]};
        return {v[30:0], rot ? v[31] : 1'b0};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        load_a = 0; load_b = 0; cap_c = 0; shift_start = 0;
    endtask

    // Advance one edge: predict from requirements, clock, compare, drop strobes.
    task automatic tick(string tag);
        logic [31:0] nC;
        logic nBusy, nDone;
        nC = mC; nBusy = mBusy; nDone = 0;
        if (!rst_n) begin
            nC = '0; nBusy = 0; mLeft = 0;
        end else if (mBusy) begin
            nC = step(mC, mDir, mRot);
            mLeft--;
            if (mLeft == 0) begin nBusy = 0; nDone = 1; end
        end else if (shift_start) begin
            nC = mA; mDir = shift_right; mRot = shift_rotate;
            mLeft = int'(shift_count);
            if (shift_count == 0) nDone = 1; else nBusy = 1;
        end else if (cap_c) begin
            case (fn_sel)
                2'b00: nC = mA + mB + {31'b0, mInv};
                2'b01: nC = step(mA, shift_right, shift_rotate);
                2'b10: nC = mA | mB;
                default: nC = mA & mB;
            endcase
        end
        if (!rst_n) begin
            mA = '0; mB = '0; mInv = 0;
        end else begin
            if (load_a) mA = a_sel_four ? 32'd4 : bus_in;
            if (load_b) begin mB = b_invert ? ~bus_in : bus_in; mInv = b_invert; end
        end
        mC = nC; mBusy = nBusy; mDone = nDone;
        @(posedge clk); #1;
        chk({tag, " C"}, c_out, mC);
        chk({tag, " busy/done"}, {30'b0, shift_busy, shift_done}, {30'b0, mBusy, mDone});
        clear_in();
    endtask

    task automatic ld_a(logic [31:0] v);
        bus_in = v; load_a = 1; a_sel_four = 0; tick("R2 load A");
    endtask
    task automatic ld_b(logic [31:0] v, logic inv);
        bus_in = v; load_b = 1; b_invert = inv; tick("R3 load B");
    endtask
    task automatic cap(logic [1:0] f, string tag);
        fn_sel = f; cap_c = 1; tick(tag);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        #1;
        tick("R1 reset"); tick("R1 reset");
        chk("R1 reset C", c_out, 32'h0);
        rst_n = 1;
        tick("R12 idle");

        // R2: constant four plus bus value.
        a_sel_four = 1; load_a = 1; tick("R2 four");
        ld_b(32'd10, 0);
        cap(2'b00, "R2 R4 add");
        chk("R2 four+10", c_out, 32'd14);

        // R5: subtract through inverted B.
        ld_a(32'd100); ld_b(32'd58, 1);
        cap(2'b00, "R5 sub");
        chk("R5 100-58", c_out, 32'd42);

        // R3: inverted load and carry-in of one.
        ld_a(32'd0); ld_b(32'd0, 1);
        cap(2'b00, "R3 carry");
        chk("R3 0+~0+1", c_out, 32'd0);
        ld_b(32'd5, 1);
        cap(2'b10, "R3 R4 or");
        chk("R3 inverted B", c_out, 32'hFFFF_FFFA);

        // R4: AND / OR.
        ld_a(32'hF0F0_1234); ld_b(32'h0FF0_FF00, 0);
        cap(2'b11, "R4 and");
        chk("R4 and", c_out, 32'h00F0_1200);
        cap(2'b10, "R4 or");
        chk("R4 or", c_out, 32'hFFF0_FF34);

        // R6: single steps in every mode.
        ld_a(32'h8000_0001);
        shift_right = 1; shift_rotate = 1; cap(2'b01, "R6 rot right");
        chk("R6 rot right", c_out, 32'hC000_0000);
        shift_right = 0; shift_rotate = 1; cap(2'b01, "R6 rot left");
        chk("R6 rot left", c_out, 32'h0000_0003);
        shift_right = 1; shift_rotate = 0; cap(2'b01, "R6 right zero");
        chk("R6 right zero", c_out, 32'h4000_0000);
        shift_right = 0; shift_rotate = 0; cap(2'b01, "R6 left zero");
        chk("R6 left zero", c_out, 32'h0000_0002);

        // R7: counted shift of 5, with mode inputs changed mid-shift.
        ld_a(32'd3);
        shift_count = 5; shift_right = 0; shift_rotate = 0; shift_start = 1;
        tick("R7 start");
        shift_right = 1; shift_rotate = 1;
        for (int i = 0; i < 5; i++) tick("R7 stepping");
        chk("R7 3<<5", c_out, 32'd96);
        chk("R7 done", {31'b0, shift_done}, 32'd1);

        // R8: zero count.
        shift_count = 0; shift_start = 1; tick("R8 zero");
        chk("R8 C=A", c_out, 32'd3);

        // R9: capture, start and loads while busy.
        ld_b(32'h1, 0);
        shift_count = 3; shift_right = 1; shift_rotate = 1; shift_start = 1;
        tick("R9 start");
        cap_c = 1; fn_sel = 2'b10; shift_start = 1; shift_count = 0; tick("R9 ignored");
        ld_a(32'h1234_5678);
        tick("R9 finish");
        chk("R9 ror3 of 3", c_out, 32'h6000_0000);
        cap(2'b00, "R9 load kept");
        chk("R9 A loaded while busy", c_out, 32'h1234_5679);

        // R10: load and capture in the same edge.
        bus_in = 32'hFFFF_0000; load_a = 1; a_sel_four = 0; cap_c = 1; fn_sel = 2'b11;
        tick("R10 same edge");
        chk("R10 old A", c_out, 32'h0);

        // R11: start beats capture.
        shift_start = 1; shift_count = 0; cap_c = 1; fn_sel = 2'b10; tick("R11 prio");
        chk("R11 start wins", c_out, 32'hFFFF_0000);

        // R12: hold.
        tick("R12 hold");
        chk("R12 hold", c_out, 32'hFFFF_0000);

        // Random mix of all strobes.
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            bus_in = $urandom;
            load_a = r[0] & r[1]; a_sel_four = r[2] & r[3];
            load_b = r[4] & r[5]; b_invert = r[6];
            cap_c = r[7]; fn_sel = r[9:8];
            shift_start = (r[13:10] == 4'h0);
            shift_count = (r[14]) ? 5'(r[19:15] & 5'h07) : r[19:15];
            shift_right = r[20]; shift_rotate = r[21];
            tick("R4 R7 R9 R10 R11 random");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule